// File: doc/BRIEF.md
# Interrupt priority register bank

This block holds one priority value for each interrupt line of an interrupt controller. Software reaches it through a 32-bit register port. Each access carries a privilege flag and four byte strobes. Four priority bytes are packed into each word. Only the upper nibble of each byte is stored. The lower nibble always reads as zero, and whatever is written to it is discarded.

The controller drives a vector of pending lines into the block. From the stored priorities, the block picks the pending line that is most urgent, meaning the one with the smallest stored value. Two lines with equal values are resolved in favour of the lower index. The pick is combinational, so a change to a pending line or to a stored priority shows in the same cycle.

An unprivileged access gets an error response. It changes no state and reads zero. An offset outside the register window is harmless: it reads zero, its writes are ignored, and it raises no error.

Top module: `irq_prio_bank`

## Requirements
- R1: After reset, every priority field reads zero. With all lines pending, the selector then reports line 0.
- R2: Priority field N sits in the word at byte offset 0x400 + 4*(N/4), in byte lane N mod 4. Lane L occupies bits [8L+7:8L], and line 239 is in lane 3 of offset 0x4EC.
- R3: On a write, each byte lane is updated only when its strobe bit be_i[L] is 1. Lanes whose strobe is 0 keep their value.
- R4: Bits [3:0] of every byte lane always read as zero, and the upper nibble of the written byte is what is stored.
- R5: A request with priv_i low raises err_o in the following cycle. That request leaves all fields unchanged and returns rdata_o equal to zero.
- R6: A privileged request to an offset below 0x400 or above 0x4EF reads zero, changes no field, and leaves err_o low.
- R7: Read data appears on rdata_o in the cycle after the request. In any cycle that does not follow a privileged in-window read, rdata_o is zero.
- R8: A write is stored at the clock edge where it is presented, so a read issued in the next cycle returns the new value.
- R9: sel_valid_o is 1 exactly when some pending_i bit is 1. sel_idx_o is then the pending line with the smallest stored priority.
- R10: Among pending lines that share the smallest priority, sel_idx_o names the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte offset bits [11:2] (word address) |
| be_i | input | 4 | Byte-lane write strobes |
| wdata_i | input | 32 | Write data |
| priv_i | input | 1 | Access is privileged |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Error response for an unprivileged access |
| pending_i | input | 240 | Pending interrupt lines |
| sel_valid_o | output | 1 | Some line is pending |
| sel_idx_o | output | 8 | Index of the most urgent pending line |

## Verification
A corrupted or misrouted field shows up in two places. The first is the next read of its word, where the wrong lane or a nonzero low nibble is visible one cycle after the request. The second is the selector, which changes its pick in the same cycle that the matching pending bit is driven. Scenarios that give distinct priorities to lines sharing a word, and others that place equal priorities on lines far apart, separate a lane swap from a tie-break error. A leaked unprivileged or out-of-window write is exposed by re-reading the targeted word at the next privileged access.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = BUS_W / LANE_W;
endpackage

// File: rtl/irq_prio_store.sv
module irq_prio_store
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 240,
  parameter int unsigned PRIO_BITS = 4,
  localparam int unsigned NUM_REGS = (NUM_IRQ + LANES - 1) / LANES,
  localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [REG_W-1:0]               reg_i,
  input  logic [LANES-1:0]               be_i,
  input  logic [BUS_W-1:0]               wdata_i,
  output logic [BUS_W-1:0]               rd_word_o,
  output logic [NUM_IRQ*PRIO_BITS-1:0]   prio_o
);
  logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_field
    localparam int unsigned LANE = n % LANES;
    localparam int unsigned TOP  = LANE * LANE_W + LANE_W - 1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[n] <= '0;
      else if (wr_en_i && reg_i == REG_W'(n / LANES) && be_i[LANE])
        prio_q[n] <= wdata_i[TOP -: PRIO_BITS];
    end
    assign prio_o[n*PRIO_BITS +: PRIO_BITS] = prio_q[n];
  end

  always_comb begin
    rd_word_o = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      int idx;
      idx = int'(reg_i) * int'(LANES) + l;
      if (idx < int'(NUM_IRQ))
        rd_word_o[l*LANE_W + LANE_W - PRIO_BITS +: PRIO_BITS] = prio_q[idx];
    end
  end

  // R5 R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> prio_o == $past(prio_o));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_IRQ   = 240,
  parameter int unsigned PRIO_BITS = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]           pend_i,
  input  logic [NUM_IRQ*PRIO_BITS-1:0] prio_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [PRIO_BITS-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < int'(NUM_IRQ); i++) begin
      if (pend_i[i] && (!valid_o || prio_i[i*PRIO_BITS +: PRIO_BITS] < best)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_i[i*PRIO_BITS +: PRIO_BITS];
      end
    end
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 240,
  parameter int unsigned PRIO_BITS = 4,
  parameter int unsigned BASE_OFF  = 32'h400,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned NUM_REGS = (NUM_IRQ + LANES - 1) / LANES,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned IDX_W    = $clog2(NUM_IRQ),
  localparam int unsigned WORD_W   = ADDR_W - 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:2]    addr_i,
  input  logic [LANES-1:0]     be_i,
  input  logic [BUS_W-1:0]     wdata_i,
  input  logic                 priv_i,
  output logic [BUS_W-1:0]     rdata_o,
  output logic                 err_o,
  input  logic [NUM_IRQ-1:0]   pending_i,
  output logic                 sel_valid_o,
  output logic [IDX_W-1:0]     sel_idx_o
);
  localparam logic [WORD_W-1:0] BASE_WORD = WORD_W'(BASE_OFF / 4);
  localparam logic [WORD_W-1:0] END_WORD  = WORD_W'(BASE_OFF / 4 + NUM_REGS);
  localparam logic [LANE_W-1:0] LANE_LOW  = LANE_W'((1 << (LANE_W - PRIO_BITS)) - 1);
  localparam logic [BUS_W-1:0]  LOW_MASK  = {LANES{LANE_LOW}};

  logic                  in_win;
  logic [WORD_W-1:0]     rel_word;
  logic                  wr_en, rd_en;
  logic [BUS_W-1:0]      rd_word;
  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat;

  assign in_win   = (addr_i >= BASE_WORD) && (addr_i < END_WORD);
  assign rel_word = addr_i - BASE_WORD;
  assign wr_en    = req_i && we_i && priv_i && in_win;
  assign rd_en    = req_i && !we_i && priv_i && in_win;

  irq_prio_store #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .reg_i    (rel_word[REG_W-1:0]),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .rd_word_o(rd_word),
    .prio_o   (prio_flat)
  );

  irq_prio_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_pick (
    .pend_i (pending_i),
    .prio_i (prio_flat),
    .valid_o(sel_valid_o),
    .idx_o  (sel_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd_en ? rd_word : '0;
      err_o   <= req_i && !priv_i;
    end
  end

  // R4
  low_nib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & LOW_MASK) == '0);
  // R5
  unpriv_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !priv_i |=> err_o && rdata_o == '0);
  // R6
  out_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && priv_i && !in_win |=> !err_o && rdata_o == '0);
  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !err_o && rdata_o == '0);
  // R9
  pick_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (int'(sel_idx_o) < int'(NUM_IRQ)) && pending_i[sel_idx_o]);
  // R9
  pick_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_i == '0 |-> !sel_valid_o);
endmodule

// File: tb/sim_irq_prio_bank.sv
module sim_irq_prio_bank;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, we_i = 1'b0, priv_i = 1'b0;
  logic [11:2]  addr_i = '0;
  logic [3:0]   be_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic         err_o;
  logic [239:0] pending_i = '0;
  logic         sel_valid_o;
  logic [7:0]   sel_idx_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .priv_i(priv_i), .rdata_o(rdata_o), .err_o(err_o),
    .pending_i(pending_i), .sel_valid_o(sel_valid_o), .sel_idx_o(sel_idx_o)
  );

  typedef struct packed {
    logic        we;
    logic        priv;
    logic [11:0] off;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 12'h400, 4'hF, 32'hA5B6C7D8, 32'h0, 1'b0, 8'd8},          // R8 full write
    '{1'b0, 1'b1, 12'h400, 4'h0, 32'h0, 32'hA0B0C0D0, 1'b0, 8'd4},          // R4 low nibble zero
    '{1'b1, 1'b1, 12'h400, 4'h5, 32'h11223344, 32'h0, 1'b0, 8'd3},          // R3 lanes 0,2
    '{1'b0, 1'b1, 12'h400, 4'h0, 32'h0, 32'hA020C040, 1'b0, 8'd3},
    '{1'b1, 1'b1, 12'h4EC, 4'h8, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd2},          // R2 line 239
    '{1'b0, 1'b1, 12'h4EC, 4'h0, 32'h0, 32'hF0000000, 1'b0, 8'd2},
    '{1'b1, 1'b0, 12'h400, 4'hF, 32'h0, 32'h0, 1'b1, 8'd5},                 // R5 unpriv write
    '{1'b0, 1'b0, 12'h400, 4'h0, 32'h0, 32'h0, 1'b1, 8'd5},                 // R5 unpriv read
    '{1'b0, 1'b1, 12'h400, 4'h0, 32'h0, 32'hA020C040, 1'b0, 8'd5},
    '{1'b1, 1'b1, 12'h4F0, 4'hF, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd6},          // R6 above window
    '{1'b0, 1'b1, 12'h4F0, 4'h0, 32'h0, 32'h0, 1'b0, 8'd6},
    '{1'b1, 1'b1, 12'h3FC, 4'hF, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd6},          // R6 below window
    '{1'b0, 1'b1, 12'h3FC, 4'h0, 32'h0, 32'h0, 1'b0, 8'd6},
    '{1'b0, 1'b1, 12'h4EC, 4'h0, 32'h0, 32'hF0000000, 1'b0, 8'd6}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic priv, input logic [11:0] off,
                        input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    req_i = 1'b1; we_i = we; priv_i = priv; addr_i = off[11:2]; be_i = be; wdata_i = wd;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; priv_i = 1'b0; be_i = '0; wdata_i = '0;
  endtask

  task automatic pick(input logic [239:0] p, input logic v, input int idx, input string rq);
    @(negedge clk);
    pending_i = p;
    #1;
    chk(sel_valid_o === v && (!v || int'(sel_idx_o) == idx), rq,
        {23'd0, sel_valid_o, sel_idx_o}, {23'd0, v, 8'(idx)});
  endtask

  function automatic logic [239:0] bits(input int a, input int b, input int c);
    logic [239:0] r = '0;
    if (a >= 0) r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    #1 chk(rdata_o == 0 && err_o == 0, "R1", rdata_o, 32'h0);
    access(1'b0, 1'b1, 12'h428, 4'h0, 32'h0);
    chk(rdata_o == 0, "R1", rdata_o, 32'h0);
    pick({240{1'b1}}, 1'b1, 0, "R1");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, VEC[i].priv, VEC[i].off, VEC[i].be, VEC[i].wd);
      chk(rdata_o === VEC[i].exp_rd && err_o === VEC[i].exp_err,
          $sformatf("R%0d vec%0d", VEC[i].rq, i), {rdata_o[31:1], err_o},
          {VEC[i].exp_rd[31:1], VEC[i].exp_err});
    end

    // R7 idle cycle after a read returns zero
    @(negedge clk);
    chk(rdata_o == 0 && err_o == 0, "R7", rdata_o, 32'h0);

    // lines: 0=4,1=C,2=2,3=A,239=F, rest 0
    pick('0, 1'b0, 0, "R9 none");
    pick(bits(1, 3, -1), 1'b1, 3, "R9");
    pick(bits(0, 2, -1), 1'b1, 2, "R9");
    pick(bits(239, -1, -1), 1'b1, 239, "R9");
    pick(bits(2, 5, -1), 1'b1, 5, "R9");
    pick(bits(9, 7, -1), 1'b1, 7, "R10");
    access(1'b1, 1'b1, 12'h464, 4'h1, 32'h0000001F);   // line 100 = 1
    access(1'b1, 1'b1, 12'h4C8, 4'h1, 32'h00000013);   // line 200 = 1
    pick(bits(0, 100, 239), 1'b1, 100, "R9");
    pick(bits(200, 100, -1), 1'b1, 100, "R10");
    pick(bits(200, 239, -1), 1'b1, 200, "R9");
    access(1'b0, 1'b1, 12'h464, 4'h0, 32'h0);
    chk(rdata_o == 32'h00000010, "R8", rdata_o, 32'h00000010);
    pending_i = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule